// File: doc/BRIEF.md
# 24-bit Processor Architectural Register State

This block keeps the architectural state of a small 24-bit processor: a bank of eight 24-bit general-purpose registers, a program counter and an 8-bit processor status word. The datapath reads two operands a cycle through two combinational read ports and retires one result a cycle through a single write port. The write port widens 8-bit and 16-bit results to 24 bits, signed or unsigned, as the instruction requires.

The program counter is not a writable register. It changes only in three ways: it is loaded once from a boot vector after reset, it advances by one 16-bit instruction, or it takes a branch target. Operand port A can return the program counter in place of a register. It then gives the current instruction address plus 2. The status word collects the four arithmetic flags, the interrupt enable and the 3-bit interrupt level. Each of them is updated from outside under its own enable.

After reset the block issues one read request for the start address. The request goes to the first entry of a vector table whose base address is an input. The block holds `ready_o` low until that word has been returned and loaded.

Top module: `cpu_arch_state`

## Requirements
- R1: Each of the eight general-purpose registers, selected by a 3-bit index, holds the last value written to it, and both read ports return the content of the register they address.
- R2: Written data is widened by `wr_size_i`. Code 0 takes bits 7:0, code 1 takes bits 15:0, and codes 2 and 3 take all 24 bits. When `wr_signed_i` is 1 the top bit of the kept field fills the upper bits; when it is 0 they are filled with zero.
- R3: With the default parameter, all general-purpose registers read zero after reset.
- R4: A read port that addresses the register being written in the same cycle returns the new, widened value.
- R5: When `rd_a_pc_i` is 1, read port A returns the program counter plus 2, modulo 2^24, instead of a register.
- R6: Bit 0 of the program counter is always 0. A boot vector or branch target with bit 0 set is loaded with that bit cleared.
- R7: Once ready, the program counter takes the branch target on the cycle after `br_en_i` is high. Otherwise it advances by 2 when `step_i` is high, and holds when neither is high. Register writes never change it.
- R8: After reset `mem_req_o` is high with `mem_addr_o` equal to `vec_base_i`, and stays high until `mem_ack_i`. On the edge with `mem_ack_i` high the program counter loads `mem_rdata_i`, then `ready_o` rises and the request drops.
- R9: While `ready_o` is low, `step_i` and `br_en_i` have no effect on the program counter.
- R10: The status word has the interrupt level in bits 7:5, interrupt enable in bit 4, C in bit 3, V in bit 2, Z in bit 1 and N in bit 0. Each flag bit k loads `flag_i[k]` only when `flag_we_i[k]` is set, and the word resets to 0.
- R11: The interrupt enable loads `ie_i` only under `ie_we_i`, and the interrupt level loads `il_i` only under `il_we_i`. Neither disturbs the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_base_i | input | 24 | Vector table base address, held stable during boot |
| mem_req_o | output | 1 | Boot vector read request |
| mem_addr_o | output | 24 | Boot vector read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 24 | Boot vector read data |
| ready_o | output | 1 | Program counter loaded, sequencing accepted |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write index |
| wr_data_i | input | 24 | Raw write data |
| wr_size_i | input | 2 | Write width code (0 byte, 1 half, 2/3 full) |
| wr_signed_i | input | 1 | Sign-extend narrow writes |
| rd_a_addr_i | input | 3 | Read port A index |
| rd_a_pc_i | input | 1 | Read port A returns program counter plus 2 |
| rd_a_data_o | output | 24 | Read port A data |
| rd_b_addr_i | input | 3 | Read port B index |
| rd_b_data_o | output | 24 | Read port B data |
| pc_o | output | 24 | Current program counter |
| step_i | input | 1 | Advance to the next instruction |
| br_en_i | input | 1 | Load branch target |
| br_target_i | input | 24 | Branch target address |
| flag_we_i | input | 4 | Per-flag write enable, bit order C V Z N from 3 to 0 |
| flag_i | input | 4 | New flag values, same order |
| ie_we_i | input | 1 | Interrupt enable write |
| ie_i | input | 1 | New interrupt enable |
| il_we_i | input | 1 | Interrupt level write |
| il_i | input | 3 | New interrupt level |
| psr_o | output | 8 | Status word |

## Verification
The hardest state to reach from the ports is a boot fetch that stalls while sequencing inputs are already active. The stimulus holds the acknowledge low for several cycles, drives branch and step requests into the waiting block, and only then returns an odd vector. The write-first path also matters. It is reached when a read index and a narrow, sign-extended write land on the same register in the same cycle. Random operations with a fixed seed do this often across all width codes, and directed cases pin the 8-bit and 16-bit sign boundaries.

// File: rtl/cpu_arch_pkg.sv
package cpu_arch_pkg;

    // Width codes of the write port
    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } wsize_e;

    // Boot sequencer states
    typedef enum logic {
        BOOT_FETCH = 1'b0,
        BOOT_RUN   = 1'b1
    } boot_e;

    // Status word; field order is visible at psr_o
    typedef struct packed {
        logic [2:0] il;
        logic       ie;
        logic       c;
        logic       v;
        logic       z;
        logic       n;
    } psr_t;

    localparam int FLAG_CNT = 4;

endpackage

// File: rtl/wdata_extend.sv
module wdata_extend
    import cpu_arch_pkg::*;
#(
    parameter int XLEN = 24
) (
    input  logic [XLEN-1:0] raw_i,
    input  wsize_e          size_i,
    input  logic            sgn_i,
    output logic [XLEN-1:0] ext_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic fill_byte;
    logic fill_half;

    always_comb begin
        fill_byte = sgn_i & raw_i[BYTE_W-1];
        fill_half = sgn_i & raw_i[HALF_W-1];
        case (size_i)
            SZ_BYTE: ext_o = {{(XLEN-BYTE_W){fill_byte}}, raw_i[BYTE_W-1:0]};
            SZ_HALF: ext_o = {{(XLEN-HALF_W){fill_half}}, raw_i[HALF_W-1:0]};
            default: ext_o = raw_i;
        endcase
    end

    initial begin
        assert (XLEN > HALF_W) else $error("AST_XLEN_WIDE: width too small"); // R2
    end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
#(
    parameter int XLEN           = 24,
    parameter int NREG           = 8,
    parameter int NRD            = 2,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(NREG)-1:0]  waddr_i,
    input  logic [XLEN-1:0]          wdata_i,
    input  logic [NRD-1:0][$clog2(NREG)-1:0] raddr_i,
    output logic [NRD-1:0][XLEN-1:0] rdata_o
);
    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            bank_d.regs[waddr_i] = wdata_i;
        end
    end

    generate
        if (CLEAR_ON_RESET) begin : g_clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bank_q <= '0;
                else        bank_q <= bank_d;
            end
        end else begin : g_noclear
            always_ff @(posedge clk) begin
                bank_q <= bank_d;
            end
        end
    endgenerate

    // Read ports, write-first
    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            logic hit;
            always_comb begin
                hit = we_i && (raddr_i[p] == waddr_i);
                rdata_o[p] = hit ? wdata_i : bank_q.regs[raddr_i[p]];
            end
        end
    endgenerate

    logic [AW-1:0] unused_aw;
    assign unused_aw = '0;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (bank_q.regs[$past(waddr_i)] == $past(wdata_i))) // R1
        else $error("write did not land");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(bank_q)) // R1
        else $error("bank changed without write");
endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import cpu_arch_pkg::*;
#(
    parameter int XLEN = 24,
    parameter int ISTEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] vec_base_i,
    output logic            mem_req_o,
    output logic [XLEN-1:0] mem_addr_o,
    input  logic            mem_ack_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            step_i,
    input  logic            br_en_i,
    input  logic [XLEN-1:0] br_target_i,
    output logic            ready_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] pc_link_o
);
    localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);
    localparam logic [XLEN-1:0] STEP_INC  = XLEN'(ISTEP);

    typedef struct packed {
        boot_e           boot;
        logic [XLEN-1:0] pc;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.boot)
            BOOT_FETCH: begin
                if (mem_ack_i) begin
                    seq_d.pc   = mem_rdata_i & EVEN_MASK;
                    seq_d.boot = BOOT_RUN;
                end
            end
            default: begin
                if (br_en_i)     seq_d.pc = br_target_i & EVEN_MASK;
                else if (step_i) seq_d.pc = seq_q.pc + STEP_INC;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.boot <= BOOT_FETCH;
            seq_q.pc   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        mem_req_o  = (seq_q.boot == BOOT_FETCH);
        mem_addr_o = vec_base_i;
        ready_o    = (seq_q.boot == BOOT_RUN);
        pc_o       = seq_q.pc;
        pc_link_o  = seq_q.pc + STEP_INC;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o) // R8
        else $error("boot request dropped early");

    AST_BOOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> (ready_o && !mem_req_o && pc_o == ($past(mem_rdata_i) & EVEN_MASK))) // R8
        else $error("boot vector not loaded");

    AST_BOOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !mem_ack_i) |=> (!ready_o && $stable(pc_o))) // R9
        else $error("pc moved during boot");

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && step_i && !br_en_i) |=> (pc_o == $past(pc_o) + STEP_INC)) // R7
        else $error("pc step wrong");

    AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && br_en_i) |=> (pc_o == ($past(br_target_i) & EVEN_MASK))) // R6
        else $error("branch load wrong");

    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o) // R8
        else $error("ready fell");
endmodule

// File: rtl/status_reg.sv
module status_reg
    import cpu_arch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLAG_CNT-1:0] flag_we_i,
    input  logic [FLAG_CNT-1:0] flag_i,
    input  logic                ie_we_i,
    input  logic                ie_i,
    input  logic                il_we_i,
    input  logic [2:0]          il_i,
    output psr_t                psr_o
);
    psr_t psr_d, psr_q;
    logic [FLAG_CNT-1:0] fl_cur, fl_nxt;

    always_comb begin
        psr_d  = psr_q;
        fl_cur = {psr_q.c, psr_q.v, psr_q.z, psr_q.n};
        fl_nxt = fl_cur;
        for (int k = 0; k < FLAG_CNT; k++) begin
            if (flag_we_i[k]) fl_nxt[k] = flag_i[k];
        end
        {psr_d.c, psr_d.v, psr_d.z, psr_d.n} = fl_nxt;
        if (ie_we_i) psr_d.ie = ie_i;
        if (il_we_i) psr_d.il = il_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psr_q <= '0;
        else        psr_q <= psr_d;
    end

    assign psr_o = psr_q;

    AST_PSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i == '0 && !ie_we_i && !il_we_i) |=> $stable(psr_q)) // R10
        else $error("status changed without enable");

    AST_IE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_we_i && !il_we_i && flag_we_i == '0) |=>
            (psr_q.ie == $past(ie_i) && psr_q.il == $past(psr_q.il) && psr_q[3:0] == $past(psr_q[3:0]))) // R11
        else $error("ie write disturbed other fields");

    AST_IL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (il_we_i && !ie_we_i && flag_we_i == '0) |=>
            (psr_q.il == $past(il_i) && psr_q[4:0] == $past(psr_q[4:0]))) // R11
        else $error("il write disturbed other fields");
endmodule

// File: rtl/cpu_arch_state.sv
module cpu_arch_state
    import cpu_arch_pkg::*;
#(
    parameter int XLEN           = 24,
    parameter int NREG           = 8,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [XLEN-1:0]          vec_base_i,
    output logic                     mem_req_o,
    output logic [XLEN-1:0]          mem_addr_o,
    input  logic                     mem_ack_i,
    input  logic [XLEN-1:0]          mem_rdata_i,
    output logic                     ready_o,
    input  logic                     wr_en_i,
    input  logic [$clog2(NREG)-1:0]  wr_addr_i,
    input  logic [XLEN-1:0]          wr_data_i,
    input  logic [1:0]               wr_size_i,
    input  logic                     wr_signed_i,
    input  logic [$clog2(NREG)-1:0]  rd_a_addr_i,
    input  logic                     rd_a_pc_i,
    output logic [XLEN-1:0]          rd_a_data_o,
    input  logic [$clog2(NREG)-1:0]  rd_b_addr_i,
    output logic [XLEN-1:0]          rd_b_data_o,
    output logic [XLEN-1:0]          pc_o,
    input  logic                     step_i,
    input  logic                     br_en_i,
    input  logic [XLEN-1:0]          br_target_i,
    input  logic [FLAG_CNT-1:0]      flag_we_i,
    input  logic [FLAG_CNT-1:0]      flag_i,
    input  logic                     ie_we_i,
    input  logic                     ie_i,
    input  logic                     il_we_i,
    input  logic [2:0]               il_i,
    output logic [7:0]               psr_o
);
    localparam int AW  = $clog2(NREG);
    localparam int NRD = 2;

    logic [XLEN-1:0]          wdata_ext;
    logic [NRD-1:0][AW-1:0]   raddr;
    logic [NRD-1:0][XLEN-1:0] rdata;
    logic [XLEN-1:0]          pc_link;
    psr_t                     psr;

    wdata_extend #(.XLEN(XLEN)) u_ext (
        .raw_i  (wr_data_i),
        .size_i (wsize_e'(wr_size_i)),
        .sgn_i  (wr_signed_i),
        .ext_o  (wdata_ext)
    );

    assign raddr[0] = rd_a_addr_i;
    assign raddr[1] = rd_b_addr_i;

    gpr_bank #(
        .XLEN           (XLEN),
        .NREG           (NREG),
        .NRD            (NRD),
        .CLEAR_ON_RESET (CLEAR_ON_RESET)
    ) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .waddr_i (wr_addr_i),
        .wdata_i (wdata_ext),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    pc_unit #(.XLEN(XLEN), .ISTEP(2)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .vec_base_i  (vec_base_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .step_i      (step_i),
        .br_en_i     (br_en_i),
        .br_target_i (br_target_i),
        .ready_o     (ready_o),
        .pc_o        (pc_o),
        .pc_link_o   (pc_link)
    );

    status_reg u_psr (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_we_i (flag_we_i),
        .flag_i    (flag_i),
        .ie_we_i   (ie_we_i),
        .ie_i      (ie_i),
        .il_we_i   (il_we_i),
        .il_i      (il_i),
        .psr_o     (psr)
    );

    always_comb begin
        rd_a_data_o = rd_a_pc_i ? pc_link : rdata[0];
        rd_b_data_o = rdata[1];
        psr_o       = psr;
    end

    AST_PC_NO_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && wr_en_i && !step_i && !br_en_i) |=> $stable(pc_o)) // R7
        else $error("register write moved pc");

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (pc_o[0] == 1'b0)) // R6
        else $error("pc odd");
endmodule

// File: tb/sim_cpu_arch_state.sv
`timescale 1ns/1ps
module sim_cpu_arch_state;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] vec_base, mem_rdata, wr_data, br_target;
    logic        mem_ack, wr_en, wr_signed, rd_a_pc, step, br_en, ie_we, ie_in, il_we;
    logic [2:0]  wr_addr, rd_a_addr, rd_b_addr, il_in;
    logic [1:0]  wr_size;
    logic [3:0]  flag_we, flag_in;
    logic        mem_req, ready;
    logic [23:0] mem_addr, rd_a_data, rd_b_data, pc;
    logic [7:0]  psr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [23:0] m_regs [8];
    logic [23:0] m_pc;
    logic [7:0]  m_psr;

    always #4 clk = ~clk;

    cpu_arch_state u0 (
        .clk(clk), .rst_n(rst_n), .vec_base_i(vec_base), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .ready_o(ready), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .wr_size_i(wr_size), .wr_signed_i(wr_signed), .rd_a_addr_i(rd_a_addr),
        .rd_a_pc_i(rd_a_pc), .rd_a_data_o(rd_a_data), .rd_b_addr_i(rd_b_addr),
        .rd_b_data_o(rd_b_data), .pc_o(pc), .step_i(step), .br_en_i(br_en),
        .br_target_i(br_target), .flag_we_i(flag_we), .flag_i(flag_in),
        .ie_we_i(ie_we), .ie_i(ie_in), .il_we_i(il_we), .il_i(il_in), .psr_o(psr)
    );

    function automatic logic [23:0] widen(logic [23:0] d, logic [1:0] sz, logic sg);
        case (sz)
            2'd0:    return sg ? {{16{d[7]}}, d[7:0]} : {16'h0, d[7:0]};
            2'd1:    return sg ? {{8{d[15]}}, d[15:0]} : {8'h0, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [23:0] peek(logic [2:0] a);
        if (wr_en && wr_addr == a) return widen(wr_data, wr_size, wr_signed);
        return m_regs[a];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_addr = 0; wr_data = 0; wr_size = 0; wr_signed = 0;
        rd_a_addr = 0; rd_a_pc = 0; rd_b_addr = 0; step = 0; br_en = 0;
        br_target = 0; flag_we = 0; flag_in = 0; ie_we = 0; ie_in = 0;
        il_we = 0; il_in = 0;
    endtask

    // Called at a negedge with inputs driven; checks reads, then state after the edge
    task automatic cycle(input string tag);
        logic [23:0] ea, eb;
        #1;
        ea = rd_a_pc ? m_pc + 24'd2 : peek(rd_a_addr);
        eb = peek(rd_b_addr);
        chk(rd_a_data == ea, {tag, " R1/R4/R5 port A"}, rd_a_data, ea);
        chk(rd_b_data == eb, {tag, " R1/R4 port B"}, rd_b_data, eb);
        @(posedge clk);
        if (wr_en) m_regs[wr_addr] = widen(wr_data, wr_size, wr_signed);
        if (br_en) m_pc = br_target & 24'hFFFFFE;
        else if (step) m_pc = m_pc + 24'd2;
        for (int k = 0; k < 4; k++) if (flag_we[k]) m_psr[k] = flag_in[k];
        if (ie_we) m_psr[4] = ie_in;
        if (il_we) m_psr[7:5] = il_in;
        @(negedge clk);
        chk(pc == m_pc, {tag, " R7/R6 pc"}, pc, m_pc);
        chk(psr == m_psr, {tag, " R10/R11 psr"}, {16'h0, psr}, {16'h0, m_psr});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=%h exp=%h", 24'h0, 24'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        rst_n = 0; mem_ack = 0; mem_rdata = 0; vec_base = 24'h000400;
        for (int i = 0; i < 8; i++) m_regs[i] = 24'h0;
        m_psr = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R8: request pending after reset
        chk(mem_req == 1'b1, "R8 request after reset", {23'h0, mem_req}, 24'h1);
        chk(mem_addr == 24'h000400, "R8 request address", mem_addr, 24'h000400);
        chk(ready == 1'b0, "R8 ready low", {23'h0, ready}, 24'h0);
        chk(psr == 8'h00, "R10 psr reset", {16'h0, psr}, 24'h0);
        // R3: all registers zero
        for (int i = 0; i < 8; i++) begin
            rd_b_addr = 3'(i);
            #1;
            chk(rd_b_data == 24'h0, "R3 reset clear", rd_b_data, 24'h0);
        end
        // R9: sequencing ignored during a stalled fetch
        step = 1; br_en = 1; br_target = 24'h00F000;
        repeat (4) @(negedge clk);
        chk(pc == 24'h0, "R9 pc frozen", pc, 24'h0);
        chk(ready == 1'b0 && mem_req == 1'b1, "R8 request held", {22'h0, ready, mem_req}, 24'h1);
        step = 0; br_en = 0;
        // R8/R6: odd vector returned
        mem_ack = 1; mem_rdata = 24'h12345F;
        @(negedge clk);
        mem_ack = 0;
        #1;
        chk(ready == 1'b1 && mem_req == 1'b0, "R8 ready after ack", {22'h0, ready, mem_req}, 24'h2);
        chk(pc == 24'h12345E, "R6 vector bit0 cleared", pc, 24'h12345E);
        m_pc = 24'h12345E;
        @(negedge clk);
        idle();

        // R2 directed widen cases, R4 bypass on same register
        wr_en = 1; wr_addr = 5; wr_data = 24'h123480; wr_size = 0; wr_signed = 1; rd_b_addr = 5;
        cycle("R2 byte signed");
        chk(rd_b_data == 24'hFFFF80, "R2 byte signed stored", rd_b_data, 24'hFFFF80);
        wr_addr = 2; wr_data = 24'h7F80FF; wr_size = 0; wr_signed = 0; rd_b_addr = 2;
        cycle("R2 byte unsigned");
        wr_addr = 3; wr_data = 24'h008001; wr_size = 1; wr_signed = 1; rd_a_addr = 3; rd_b_addr = 3;
        cycle("R2 half signed");
        wr_addr = 4; wr_data = 24'hFF8001; wr_size = 1; wr_signed = 0; rd_a_addr = 4;
        cycle("R2 half unsigned");
        wr_addr = 7; wr_data = 24'hABCDEF; wr_size = 3; wr_signed = 1; rd_a_addr = 7;
        cycle("R2 full alt code");
        idle();
        rd_b_addr = 3;
        #1;
        chk(rd_b_data == 24'hFF8001, "R2 half signed stored", rd_b_data, 24'hFF8001);
        // R5 pc operand
        rd_a_pc = 1;
        cycle("R5 pc operand");
        // R6/R7 branch beats step, odd target
        br_en = 1; step = 1; br_target = 24'h0007F3;
        cycle("R7 branch priority");
        br_en = 0; step = 1;
        cycle("R7 step");
        // R7: wraps at top of address space
        br_en = 1; step = 0; br_target = 24'hFFFFFF;
        cycle("R6 branch top");
        br_en = 0; step = 1; rd_a_pc = 1;
        cycle("R7 wrap");
        idle();
        // R11 ie and il isolation, R10 masked flags
        flag_we = 4'b1111; flag_in = 4'b1010;
        cycle("R10 all flags");
        flag_we = 4'b0100; flag_in = 4'b0101;
        cycle("R10 masked flag");
        flag_we = 0; ie_we = 1; ie_in = 1; il_in = 3'd5;
        cycle("R11 ie only");
        ie_we = 0; ie_in = 0; il_we = 1; il_in = 3'd6;
        cycle("R11 il only");
        idle();

        // Random mix
        for (int n = 0; n < 600; n++) begin
            wr_en     = 1'($urandom);
            wr_addr   = 3'($urandom);
            wr_data   = 24'($urandom);
            wr_size   = 2'($urandom);
            wr_signed = 1'($urandom);
            rd_a_addr = ($urandom % 3 == 0) ? wr_addr : 3'($urandom);
            rd_b_addr = ($urandom % 3 == 0) ? wr_addr : 3'($urandom);
            rd_a_pc   = ($urandom % 5 == 0);
            step      = 1'($urandom);
            br_en     = ($urandom % 6 == 0);
            br_target = 24'($urandom);
            flag_we   = 4'($urandom);
            flag_in   = 4'($urandom);
            ie_we     = ($urandom % 4 == 0);
            ie_in     = 1'($urandom);
            il_we     = ($urandom % 4 == 0);
            il_in     = 3'($urandom);
            cycle("random");
        end
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule